// File: doc/BRIEF.md
# PLL Divider Search Engine

This block picks the divider settings for a frequency synthesiser. After a start pulse it takes a reference frequency and a requested output frequency, both in Hz. It then walks through the allowed pre-divider values in ascending order. For each one it works out the feedback divider, and from that the frequency the pair would produce. It keeps the pair whose result lies closest to the request.

All arithmetic uses one shared shift-and-subtract divider, so each candidate costs a fixed number of cycles. When the search ends, the engine raises `done` for one cycle. It also presents the chosen pre-divider, the chosen feedback divider, the frequency they produce and a flag that says whether any legal pair was found. These outputs stay unchanged until the next search finishes. A control sequencer would start the engine and then copy the result into the synthesiser's divider fields.

Top module: `pll_div_search`

## Requirements
- R1: While reset is high, and after it until the first search ends, `done` and `valid` are 0 and `prediv`, `fbdiv` and `out_hz` are 0.
- R2: The comparison reference `fref` is `ref_hz` divided by two, rounded down. The working target `fout` is `target_hz` limited to at most 1,000,000,000.
- R3: A pre-divider value p is a candidate only when 5,000,000·p ≤ fref ≤ 40,000,000·p and 1 ≤ p ≤ 31. Candidates are tried in increasing order of p.
- R4: For a candidate p, the feedback value is floor(fout·p / fref). The candidate is skipped when this value is below 12, above 511, or equal to 15.
- R5: A kept candidate produces floor(fb·fref / p) Hz. Its error is the absolute difference between that frequency and `fout`.
- R6: A candidate with zero error ends the search at once and becomes the result. The remaining candidates are not visited, so such a search with a single visited candidate completes in under 400 cycles.
- R7: A candidate whose error is not zero replaces the stored best only when its error is strictly smaller. On equal error the lower p is kept.
- R8: When no candidate survives, the result has `valid` = 0 and `out_hz`, `prediv` and `fbdiv` all equal to 0.
- R9: `done` is high for exactly one cycle per search. `prediv`, `fbdiv`, `out_hz` and `valid` change only in the cycle where `done` is high.
- R10: A `start` that arrives while a search is running is ignored. The running search finishes with its own inputs and produces a single `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search; sampled only when idle |
| ref_hz | input | 32 | Reference frequency in Hz |
| target_hz | input | 32 | Requested output frequency in Hz |
| done | output | 1 | One-cycle pulse when the result is updated |
| valid | output | 1 | A legal divider pair was found |
| prediv | output | 5 | Selected pre-divider |
| fbdiv | output | 9 | Selected feedback divider |
| out_hz | output | 32 | Frequency produced by the selected pair |

## Verification
The assertions take for granted that `start` is a single-cycle pulse. They also assume that `ref_hz` and `target_hz` may change freely once the engine has sampled them, since the engine keeps its own copy.

The stimulus gives each search a single start pulse and waits for `done` before issuing the next one. The one exception is the deliberate mid-search start used to test R10.

The references used place the candidate window at the low edge, in the middle and at the upper limit of 31. They also include an empty window and a zero reference. The targets include values above the 1 GHz cap, values that land on an exact match, values that hit the forbidden feedback value 15, and values below the minimum of 12.

// File: rtl/pds_pkg.sv
package pds_pkg;

    localparam int FREQ_W  = 32;
    localparam int PRE_W   = 5;
    localparam int FB_W    = 9;
    localparam int DIV_W   = 48;
    localparam int PROD_W  = 64;

    localparam logic [FREQ_W-1:0] FOUT_CAP  = 32'd1_000_000_000;
    localparam logic [FREQ_W-1:0] CMP_HI_HZ = 32'd40_000_000;
    localparam logic [FREQ_W-1:0] CMP_LO_HZ = 32'd5_000_000;
    localparam int FB_MIN  = 12;
    localparam int FB_MAX  = 511;
    localparam int FB_HOLE = 15;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PICK,
        S_QFB,
        S_QHZ,
        S_FIN
    } state_e;

    typedef struct packed {
        logic              ok;
        logic [PRE_W-1:0]  pre;
        logic [FB_W-1:0]   fb;
        logic [FREQ_W-1:0] hz;
        logic [FREQ_W-1:0] err;
    } pick_t;

    function automatic logic [FREQ_W-1:0] clamp_target(input logic [FREQ_W-1:0] t);
        return (t > FOUT_CAP) ? FOUT_CAP : t;
    endfunction

    function automatic logic [FREQ_W-1:0] abs_diff(input logic [FREQ_W-1:0] a,
                                                   input logic [FREQ_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/rdiv_seq.sv
module rdiv_seq #(
    parameter int NW = 48,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          fin,
    output logic [NW-1:0] quo
);
    localparam int CW = $clog2(NW + 1);

    logic [DW-1:0] rem;
    logic [DW-1:0] den_q;
    logic [NW-1:0] sh;
    logic [CW-1:0] cnt;
    logic          run;
    logic [DW:0]   trial;
    logic [DW:0]   diff;
    logic          fit;

    always_comb begin
        trial = {rem, sh[NW-1]};
        diff  = trial - {1'b0, den_q};
        fit   = (trial >= {1'b0, den_q});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem   <= '0;
            den_q <= '0;
            sh    <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            fin   <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                sh    <= num;
                den_q <= den;
                rem   <= '0;
                cnt   <= CW'(NW);
                run   <= 1'b1;
            end else if (run) begin
                rem <= fit ? diff[DW-1:0] : trial[DW-1:0];
                sh  <= {sh[NW-2:0], fit};
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    run <= 1'b0;
                    fin <= 1'b1;
                end
            end
        end
    end

    assign quo = sh;

endmodule

// File: rtl/pds_judge.sv
module pds_judge
    import pds_pkg::*;
#(
    parameter int CAND_W = PRE_W + 1
) (
    input  logic [FREQ_W-1:0] fref,
    input  logic [CAND_W-1:0] cand,
    input  logic [DIV_W-1:0]  fb_quo,
    output logic              in_win,
    output logic              fb_legal
);
    logic [PROD_W-1:0] hi_lim;
    logic [PROD_W-1:0] lo_lim;
    logic [PROD_W-1:0] fref_w;

    always_comb begin
        fref_w   = PROD_W'(fref);
        hi_lim   = PROD_W'(CMP_HI_HZ) * PROD_W'(cand);
        lo_lim   = PROD_W'(CMP_LO_HZ) * PROD_W'(cand);
        in_win   = (cand != '0) && (fref_w <= hi_lim) && (lo_lim <= fref_w);
        fb_legal = (fb_quo >= DIV_W'(FB_MIN)) && (fb_quo <= DIV_W'(FB_MAX))
                   && (fb_quo != DIV_W'(FB_HOLE));
    end

endmodule

// File: rtl/pll_div_search.sv
module pll_div_search
    import pds_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FREQ_W-1:0] ref_hz,
    input  logic [FREQ_W-1:0] target_hz,
    output logic              done,
    output logic              valid,
    output logic [PRE_W-1:0]  prediv,
    output logic [FB_W-1:0]   fbdiv,
    output logic [FREQ_W-1:0] out_hz
);
    localparam int CAND_W = PRE_W + 1;
    localparam logic [CAND_W-1:0] CAND_LAST = CAND_W'((1 << PRE_W) - 1);

    state_e             state;
    logic [FREQ_W-1:0]  fref_q;
    logic [FREQ_W-1:0]  fout_q;
    logic [CAND_W-1:0]  cand;
    logic [FB_W-1:0]    fb_q;
    pick_t              best;

    logic               div_go;
    logic [DIV_W-1:0]   div_num;
    logic [FREQ_W-1:0]  div_den;
    logic               div_fin;
    logic [DIV_W-1:0]   div_quo;
    logic               in_win;
    logic               fb_legal;
    logic [FREQ_W-1:0]  hz_now;
    logic [FREQ_W-1:0]  err_now;
    logic               last_cand;

    pds_judge #(.CAND_W(CAND_W)) u_judge (
        .fref     (fref_q),
        .cand     (cand),
        .fb_quo   (div_quo),
        .in_win   (in_win),
        .fb_legal (fb_legal)
    );

    rdiv_seq #(.NW(DIV_W), .DW(FREQ_W)) u_div (
        .clk (clk),
        .rst (rst),
        .go  (div_go),
        .num (div_num),
        .den (div_den),
        .fin (div_fin),
        .quo (div_quo)
    );

    always_comb begin
        hz_now    = div_quo[FREQ_W-1:0];
        err_now   = abs_diff(fout_q, hz_now);
        last_cand = (cand == CAND_LAST);
        if (state == S_PICK) begin
            div_num = DIV_W'(fout_q) * DIV_W'(cand);
            div_den = fref_q;
        end else begin
            div_num = DIV_W'(div_quo[FB_W-1:0]) * DIV_W'(fref_q);
            div_den = FREQ_W'(cand);
        end
        div_go = ((state == S_PICK) && in_win)
               || ((state == S_QFB) && div_fin && fb_legal);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_IDLE;
            fref_q <= '0;
            fout_q <= '0;
            cand   <= '0;
            fb_q   <= '0;
            best   <= '0;
            done   <= 1'b0;
            valid  <= 1'b0;
            prediv <= '0;
            fbdiv  <= '0;
            out_hz <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        fref_q <= ref_hz >> 1;
                        fout_q <= clamp_target(target_hz);
                        cand   <= CAND_W'(1);
                        best   <= '0;
                        state  <= S_PICK;
                    end
                end
                S_PICK: begin
                    if (in_win)         state <= S_QFB;
                    else if (last_cand) state <= S_FIN;
                    else                cand  <= cand + 1'b1;
                end
                S_QFB: begin
                    if (div_fin) begin
                        if (fb_legal) begin
                            fb_q  <= div_quo[FB_W-1:0];
                            state <= S_QHZ;
                        end else if (last_cand) begin
                            state <= S_FIN;
                        end else begin
                            cand  <= cand + 1'b1;
                            state <= S_PICK;
                        end
                    end
                end
                S_QHZ: begin
                    if (div_fin) begin
                        if (err_now == '0) begin
                            best  <= '{ok: 1'b1, pre: cand[PRE_W-1:0], fb: fb_q,
                                       hz: hz_now, err: '0};
                            state <= S_FIN;
                        end else begin
                            if (!best.ok || (err_now < best.err))
                                best <= '{ok: 1'b1, pre: cand[PRE_W-1:0], fb: fb_q,
                                          hz: hz_now, err: err_now};
                            if (last_cand) begin
                                state <= S_FIN;
                            end else begin
                                cand  <= cand + 1'b1;
                                state <= S_PICK;
                            end
                        end
                    end
                end
                S_FIN: begin
                    valid  <= best.ok;
                    prediv <= best.pre;
                    fbdiv  <= best.fb;
                    out_hz <= best.hz;
                    done   <= 1'b1;
                    state  <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pds_checker.sv
module pds_checker
    import pds_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done,
    input logic              valid,
    input logic [PRE_W-1:0]  prediv,
    input logic [FB_W-1:0]   fbdiv,
    input logic [FREQ_W-1:0] out_hz
);
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    a_r9_hold_outputs: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable({valid, prediv, fbdiv, out_hz}));

    a_r4_fb_legal: assert property (@(posedge clk) disable iff (rst)
        (done && valid) |-> (fbdiv >= FB_W'(FB_MIN) && fbdiv != FB_W'(FB_HOLE)
                             && prediv != '0));

    a_r8_invalid_zero: assert property (@(posedge clk) disable iff (rst)
        (done && !valid) |-> (out_hz == '0 && prediv == '0 && fbdiv == '0));

    a_r2_output_capped: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_hz <= FOUT_CAP));

endmodule

bind pll_div_search pds_checker u_chk (
    .clk    (clk),
    .rst    (rst),
    .done   (done),
    .valid  (valid),
    .prediv (prediv),
    .fbdiv  (fbdiv),
    .out_hz (out_hz)
);

// File: tb/sim_pll_div_search.sv
module sim_pll_div_search;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] ref_hz = '0;
    logic [31:0] target_hz = '0;
    logic        done;
    logic        valid;
    logic [4:0]  prediv;
    logic [8:0]  fbdiv;
    logic [31:0] out_hz;

    pll_div_search u0 (
        .clk(clk), .rst(rst), .start(start), .ref_hz(ref_hz), .target_hz(target_hz),
        .done(done), .valid(valid), .prediv(prediv), .fbdiv(fbdiv), .out_hz(out_hz)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        longint unsigned pre;
        longint unsigned fb;
        longint unsigned hz;
        bit              ok;
        string           tag;
    } exp_t;

    exp_t exp_q[$];
    exp_t last_e;
    int   n_chk = 0;
    int   n_err = 0;
    bit   finished = 0;

    task automatic chk_eq(string req, longint unsigned act, longint unsigned expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic exp_t model(longint unsigned rf, longint unsigned tg, string tag);
        exp_t e;
        longint unsigned fref, fout, lo, hi, fb, a, d, be;
        e.pre = 0; e.fb = 0; e.hz = 0; e.ok = 0; e.tag = tag; be = 0;
        fref = rf / 2;
        fout = (tg > 64'd1000000000) ? 64'd1000000000 : tg;
        lo = (fref + 64'd39999999) / 64'd40000000;
        if (lo < 1) lo = 1;
        hi = fref / 64'd5000000;
        if (hi > 31) hi = 31;
        for (longint unsigned p = lo; p <= hi; p++) begin
            fb = fout * p / fref;
            if (fb < 12 || fb > 511 || fb == 15) continue;
            a = fb * fref / p;
            d = (fout > a) ? fout - a : a - fout;
            if (d == 0) begin
                e.pre = p; e.fb = fb; e.hz = a; e.ok = 1;
                break;
            end
            if (!e.ok || d < be) begin
                e.pre = p; e.fb = fb; e.hz = a; e.ok = 1; be = d;
            end
        end
        return e;
    endfunction

    // Scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_err++;
                $display("FAIL R10 unexpected done actual=1 expected=0");
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk_eq({"R8 valid ", e.tag}, valid, e.ok);
                chk_eq({"R3 prediv ", e.tag}, prediv, e.pre);
                chk_eq({"R4 fbdiv ", e.tag}, fbdiv, e.fb);
                chk_eq({"R5 out_hz ", e.tag}, out_hz, e.hz);
                last_e = e;
            end
        end
    end

    task automatic run_case(longint unsigned rf, longint unsigned tg, string tag,
                            output int lat);
        exp_q.push_back(model(rf, tg, tag));
        @(negedge clk);
        ref_hz = rf[31:0]; target_hz = tg[31:0]; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done) begin
            @(negedge clk);
            lat++;
        end
        @(negedge clk);
        chk_eq({"R9 done one cycle ", tag}, done, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int lat;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk_eq("R1 done in reset", done, 0);
        chk_eq("R1 valid in reset", valid, 0);
        chk_eq("R1 out_hz in reset", out_hz, 0);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk_eq("R1 prediv after reset", prediv, 0);
        chk_eq("R1 fbdiv after reset", fbdiv, 0);

        run_case(64'd24000000, 64'd480000000, "exact p1", lat);       // R6
        run_case(64'd24000000, 64'd2000000000, "cap and tie", lat);   // R2, R7
        run_case(64'd24000000, 64'd180000000, "hole 15", lat);        // R4
        run_case(64'd8000000, 64'd500000000, "empty window", lat);    // R3, R8
        run_case(64'd24000000, 64'd50000000, "fb below min", lat);    // R4, R8
        run_case(64'd24000000, 64'd100000000, "near miss", lat);      // R5
        run_case(64'd0, 64'd300000000, "zero ref", lat);              // R8
        run_case(64'd100000000, 64'd333333333, "mid window", lat);    // R7
        run_case(64'd2000000000, 64'd1000000000, "exact p25", lat);   // R6
        n_chk++;
        if (lat >= 400) begin
            n_err++;
            $display("FAIL R6 early stop latency actual=%0d expected=<400", lat);
        end
        run_case(64'd400000000, 64'd777777777, "full scan", lat);     // R3

        for (int i = 0; i < 12; i++) begin
            longint unsigned rf, tg;
            rf = 64'd10000000 + longint'($urandom_range(390000000));
            tg = longint'($urandom_range(1200000000));
            run_case(rf, tg, "random", lat);
        end

        // R9 hold: outputs unchanged while idle
        repeat (10) @(negedge clk);
        chk_eq("R9 hold out_hz", out_hz, last_e.hz);
        chk_eq("R9 hold prediv", prediv, last_e.pre);

        // R10: second start during a search is ignored
        exp_q.push_back(model(64'd400000000, 64'd777777777, "busy"));
        @(negedge clk);
        ref_hz = 32'd400000000; target_hz = 32'd777777777; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (30) @(negedge clk);
        ref_hz = 32'd24000000; target_hz = 32'd480000000; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done) @(negedge clk);
        repeat (4000) @(negedge clk);
        chk_eq("R10 single result", exp_q.size(), 0);
        chk_eq("R10 kept first inputs", fbdiv, last_e.fb);

        finished = 1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule